// File: doc/BRIEF.md
# Segmented Spare-Column Shift Steering

This block sits between a memory array's data port and its physical columns. The array's columns are split into equal segments of consecutive columns. Each segment has one extra spare column at its high end. After manufacturing test, software programs one repair entry per segment. Each entry is a valid flag plus the index of the failed column.

On the write path, bits below the failed column go straight through. Every bit from the failed column upward moves one physical column higher, so the spare column takes the segment's top bit. The failed column itself is driven low. The read path applies the inverse shift, so the data port always sees a contiguous word, whatever the failed cell holds. Both paths are combinational.

A segment whose repair entry is clear passes data straight through and drives its spare low. A flag reports configurations that ask one segment to repair more than one column. The bad request is not stored, and the flag stays set until reset. A second failure cannot borrow another segment's spare.

Top module: `col_shift_repair`

## Requirements
- R1: After reset every segment reads back as not repaired (valid 0, index 0), the write path is the identity, and each spare column (physical bit SEG_W of its segment) is 0.
- R2: For a repaired segment with failed index f, physical column c of the segment carries data bit c when c < f, and data bit c-1 when c > f. Here c runs 0..SEG_W, and c = SEG_W is the spare.
- R3: The physical column at the failed index is driven 0 on the write path.
- R4: On the read path, data bit d of a segment comes from physical column d when d < f, and from physical column d+1 otherwise. With no repair, data bit d comes from physical column d and the spare is ignored.
- R5: A write followed by a read through any legal repair setting returns the original word, whatever value the failed physical column returns.
- R6: A configuration write (cfg_we) loads {cfg_valid, cfg_idx} into the segment selected by cfg_seg, on the next clock. Other segments are unchanged. cfg_rdata returns segment s in bits [s*(IDX_W+1) +: IDX_W+1], with the valid flag as the MSB of each field.
- R7: A configuration write with cfg_valid=1 to a segment that already holds a valid repair at a different index is rejected: the entry is unchanged and fault sets on the next clock. Rewriting the same index, or clearing the entry, is accepted.
- R8: fault stays set until reset, and a rejected write in one segment never consumes another segment's spare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Repair entry write strobe |
| cfg_seg | input | SEG_IDX_W | Segment selected for the write |
| cfg_valid | input | 1 | Repair enable for the written entry |
| cfg_idx | input | IDX_W | Failed column index within the segment |
| cfg_rdata | output | NSEG*(IDX_W+1) | Read-back of all repair entries |
| fault | output | 1 | Sticky unrepairable-configuration flag |
| wr_data | input | DATA_W | Logical write word |
| wr_phys | output | PHYS_W | Steered word to the physical columns |
| rd_phys | input | PHYS_W | Word read from the physical columns |
| rd_data | output | DATA_W | Unsteered logical read word |

## Verification
The steering is tried with the failed index at 0, at the top regular column and at random middle positions, and also with one segment repaired and the other not. This separates off-by-one shift errors from errors in the segment boundaries. Walking-one words locate each shifted bit exactly. Random words with garbage injected on the failed physical column show whether the read path really skips that column. Repeated writes to a repaired segment, with a different index, with the same index and with a clear request, separate a rejected conflict from a legal rewrite or release. Checks on the other segment's entry show that a spare is never shared.

// File: rtl/col_shift_repair.sv
module col_shift_repair #(
  parameter int NSEG  = 2,
  parameter int SEG_W = 16,
  localparam int IDX_W     = (SEG_W > 1) ? $clog2(SEG_W) : 1,
  localparam int SEG_IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1,
  localparam int DATA_W    = NSEG * SEG_W,
  localparam int PHYS_W    = NSEG * (SEG_W + 1),
  localparam int ENT_W     = IDX_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [SEG_IDX_W-1:0]  cfg_seg,
  input  logic                  cfg_valid,
  input  logic [IDX_W-1:0]      cfg_idx,
  output logic [NSEG*ENT_W-1:0] cfg_rdata,
  output logic                  fault,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [PHYS_W-1:0]     wr_phys,
  input  logic [PHYS_W-1:0]     rd_phys,
  output logic [DATA_W-1:0]     rd_data
);

  logic [NSEG-1:0] rep_v;
  logic [IDX_W-1:0] rep_i [NSEG];

  logic conflict;
  assign conflict = cfg_we && cfg_valid && rep_v[cfg_seg] && (rep_i[cfg_seg] != cfg_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_v <= '0;
      for (int s = 0; s < NSEG; s++) rep_i[s] <= '0;
      fault <= 1'b0;
    end else begin
      if (conflict) fault <= 1'b1;
      else if (cfg_we) begin
        rep_v[cfg_seg] <= cfg_valid;
        rep_i[cfg_seg] <= cfg_valid ? cfg_idx : '0;
      end
    end
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    assign cfg_rdata[s*ENT_W +: ENT_W] = {rep_v[s], rep_i[s]};
    for (genvar c = 0; c <= SEG_W; c++) begin : g_wcol
      localparam int P = s*(SEG_W+1) + c;
      if (c == 0) begin : g_lo
        assign wr_phys[P] = (rep_v[s] && rep_i[s] == 0) ? 1'b0 : wr_data[s*SEG_W];
      end else if (c == SEG_W) begin : g_sp
        assign wr_phys[P] = rep_v[s] ? wr_data[s*SEG_W + SEG_W-1] : 1'b0;
      end else begin : g_mid
        assign wr_phys[P] = !rep_v[s] || (c < int'(rep_i[s])) ? wr_data[s*SEG_W + c] :
                            (c == int'(rep_i[s]))             ? 1'b0 :
                                                                wr_data[s*SEG_W + c - 1];
      end
    end
    for (genvar d = 0; d < SEG_W; d++) begin : g_rcol
      localparam int P = s*(SEG_W+1) + d;
      assign rd_data[s*SEG_W + d] = (rep_v[s] && d >= int'(rep_i[s])) ? rd_phys[P+1] : rd_phys[P];
    end

    // R3
    failed_col_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rep_v[s] |-> !wr_phys[s*(SEG_W+1) + int'(rep_i[s])]);
    // R1
    spare_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rep_v[s] |-> !wr_phys[s*(SEG_W+1) + SEG_W]);
  end

  // R8
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);
  // R7
  conflict_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |=> fault && $stable(cfg_rdata));
  // R6
  idle_cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_rdata));
  // R5
  loopback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_phys == wr_phys) |-> (rd_data == wr_data));

endmodule

// File: tb/col_shift_repair_test.sv
module col_shift_repair_test;
  localparam int NSEG = 2, SEG_W = 16, IDX_W = 4, SEG_IDX_W = 1;
  localparam int DATA_W = 32, PHYS_W = 34, ENT_W = 5;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_valid = 0;
  logic [SEG_IDX_W-1:0] cfg_seg = 0;
  logic [IDX_W-1:0] cfg_idx = 0;
  logic [NSEG*ENT_W-1:0] cfg_rdata;
  logic fault;
  logic [DATA_W-1:0] wr_data = 0, rd_data;
  logic [PHYS_W-1:0] wr_phys, rd_phys = 0;

  int checks = 0, fails = 0;
  bit mv [NSEG];
  int mi [NSEG];

  col_shift_repair #(.NSEG(NSEG), .SEG_W(SEG_W)) uut (.*);

  always #10 clk = ~clk;

  initial begin
    #4_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  function automatic logic [PHYS_W-1:0] exp_wr(logic [DATA_W-1:0] d);
    logic [PHYS_W-1:0] p = '0;
    for (int s = 0; s < NSEG; s++)
      for (int c = 0; c <= SEG_W; c++) begin
        int b = s*(SEG_W+1) + c;
        if (!mv[s]) p[b] = (c < SEG_W) ? d[s*SEG_W+c] : 1'b0;
        else if (c < mi[s]) p[b] = d[s*SEG_W+c];
        else if (c == mi[s]) p[b] = 1'b0;
        else p[b] = d[s*SEG_W+c-1];
      end
    return p;
  endfunction

  function automatic logic [DATA_W-1:0] exp_rd(logic [PHYS_W-1:0] p);
    logic [DATA_W-1:0] d;
    for (int s = 0; s < NSEG; s++)
      for (int k = 0; k < SEG_W; k++)
        d[s*SEG_W+k] = p[s*(SEG_W+1) + k + ((mv[s] && k >= mi[s]) ? 1 : 0)];
    return d;
  endfunction

  function automatic logic [NSEG*ENT_W-1:0] exp_cfg();
    logic [NSEG*ENT_W-1:0] r;
    for (int s = 0; s < NSEG; s++) r[s*ENT_W +: ENT_W] = {mv[s], IDX_W'(mi[s])};
    return r;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(int s, bit v, int idx);
    @(negedge clk);
    cfg_we = 1; cfg_seg = SEG_IDX_W'(s); cfg_valid = v; cfg_idx = IDX_W'(idx);
    @(negedge clk);
    cfg_we = 0;
    if (!(v && mv[s] && mi[s] != idx)) begin mv[s] = v; mi[s] = v ? idx : 0; end
  endtask

  task automatic path(string req, logic [DATA_W-1:0] d, bit garbage);
    logic [PHYS_W-1:0] p;
    wr_data = d; #1;
    chk({req, " wr"}, 64'(wr_phys), 64'(exp_wr(d)));
    p = wr_phys;
    if (garbage)
      for (int s = 0; s < NSEG; s++)
        if (mv[s]) p[s*(SEG_W+1)+mi[s]] = $urandom_range(0, 1);
    rd_phys = p; #1;
    chk({req, " rd"}, 64'(rd_data), 64'(d));
    rd_phys = $urandom(); #1;
    chk("R4 rd", 64'(rd_data), 64'(exp_rd(rd_phys)));
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int s = 0; s < NSEG; s++) begin mv[s] = 0; mi[s] = 0; end
    #35 rst_n = 1;
    @(negedge clk);
    chk("R1 cfg", 64'(cfg_rdata), 64'(0));
    chk("R1 fault", 64'(fault), 64'(0));
    path("R1", 32'hA5C3_0FF0, 0);
    for (int k = 0; k < DATA_W; k++) path("R2", 32'(1) << k, 0);
    cfg(0, 1, 0);  cfg(1, 1, 15);
    chk("R6 cfg", 64'(cfg_rdata), 64'(exp_cfg()));
    for (int k = 0; k < DATA_W; k++) path("R2", 32'(1) << k, 0);
    path("R3", 32'hFFFF_FFFF, 0);
    cfg(1, 0, 0);
    chk("R6 clr", 64'(cfg_rdata), 64'(exp_cfg()));
    path("R4", 32'hDEAD_BEEF, 1);
    cfg(1, 1, 7); cfg(1, 1, 7);
    chk("R7 same idx", 64'(fault), 64'(0));
    cfg(0, 1, 9);
    chk("R7 reject", 64'(cfg_rdata), 64'(exp_cfg()));
    chk("R7 fault", 64'(fault), 64'(1));
    chk("R8 other seg", 64'(cfg_rdata[ENT_W +: ENT_W]), 64'({1'b1, 4'd7}));
    for (int n = 0; n < 200; n++) begin
      int s = $urandom_range(0, 1);
      cfg(s, 0, 0);
      cfg(s, $urandom_range(0, 1), $urandom_range(0, SEG_W-1));
      chk("R6 rand", 64'(cfg_rdata), 64'(exp_cfg()));
      path("R5", $urandom(), 1);
    end
    chk("R8 sticky", 64'(fault), 64'(1));
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule